// File: doc/BRIEF.md
# Qualified GPIO Port with Atomic Bit Update

A general-purpose I/O port of up to 16 pins, controlled over a simple synchronous register bus. The bus has one write strobe, a 3-bit address, 16-bit write data, and combinational read data. The port holds an output latch, a direction register, a pin-function register and an input-qualification period. Three write-only addresses (set, clear, toggle) change single latch bits without a read-modify-write sequence.

Each implemented pin drives an output enable and an output level to its pad and returns the pad level. That level passes through a two-stage synchroniser and a per-pin qualifier before it can be read. One shared tick generator paces every qualifier, so a noisy input is accepted only after it has been stable across several spaced samples. A reduced variant implements fewer pins. Its missing upper bits can be neither written nor read.

Top module: `gpio_port`

## Requirements
- R1: After reset every register is 0. All pad output enables and output levels are 0, and a read of any address returns 0.
- R2: Address 4 holds the direction. A 1 makes the pin an output (pad_oe_o bit = 1) and a 0 makes it an input. Writing 0xFF00 drives bits 15..8 and leaves bits 7..0 as inputs.
- R3: Address 5 holds the pin function. A bit of 0 selects plain digital I/O. A bit of 1 hands the pin away, so its output enable is 0 whatever the direction. The register reads back what was written.
- R4: A write to address 1 forces to 1 each latch bit whose write-data bit is 1 and leaves every other bit unchanged.
- R5: A write to address 2 forces to 0 each latch bit whose write-data bit is 1 and leaves every other bit unchanged.
- R6: A write to address 3 inverts each latch bit whose write-data bit is 1 and leaves every other bit unchanged.
- R7: A write to address 0 loads the whole latch. pad_out_o always shows the latch. A read of address 0 returns the qualified pad levels, not the latch.
- R8: Reads of addresses 1, 2, 3 and 7 return 0. Address 6 reads back the qualification period.
- R9: With a period of 0 (no qualification), a pad change appears on a read of address 0 after the third rising clock edge.
- R10: With a period Q > 0, each pin is sampled once every 2*Q cycles. A new level is accepted only when six consecutive samples agree, so a shorter pulse is rejected.
- R11: With NUM_PINS = 15, bit 15 ignores writes to every register. It reads as 0, and its output enable and output level stay 0.
- R12: An output pin returns its own driven level through the input path. With bits 15..8 looped back to 7..0, setting 0x5500 reads back 0x5555, and then toggling 0xFF00 reads back 0xAAAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pad_in_i | input | 16 | Pad levels returned from the pins |
| pad_oe_o | output | 16 | Per-pin output enable |
| pad_out_o | output | 16 | Per-pin output level |

## Verification
The hardest case to reach is a qualifier rejecting a pulse that is long enough to be synchronised but too short to collect six agreeing samples. The outcome also depends on where the shared tick sits when the pulse arrives. The bench programs a period of 2, holds the pad low long enough for the history to settle, and then drives an 8-cycle high pulse on every input. It reads the port after the pulse has gone and again after a long stable level. A cycle-exact model follows the tick phase throughout, so every intermediate read is also compared. Loopback wiring in the bench lets output pins feed input pins of the same port. This is how the set, clear and toggle results reach the read path.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_SET  = 3'd1,
    REG_CLR  = 3'd2,
    REG_TGL  = 3'd3,
    REG_DIR  = 3'd4,
    REG_MUX  = 3'd5,
    REG_QUAL = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_qual_tick.sv
module gpio_qual_tick #(
  parameter int QUAL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [QUAL_W-1:0] qual_i,
  output logic              strobe_o,
  output logic              bypass_o
);
  localparam int CNT_W = QUAL_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             hit;

  assign limit    = {qual_i, 1'b0} - CNT_W'(1);
  assign bypass_o = (qual_i == '0);
  assign hit      = (cnt_q >= limit);
  assign strobe_o = bypass_o | hit;

  // period of 2*Q cycles; counter parked while bypassed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (bypass_o) cnt_q <= '0;
    else if (hit)      cnt_q <= '0;
    else               cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/gpio_pin_qual.sv
module gpio_pin_qual #(
  parameter int SAMPLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic strobe_i,
  input  logic bypass_i,
  output logic pin_o
);
  localparam int HIST_W = SAMPLES - 1;

  logic              s1_q, s2_q;
  logic [HIST_W-1:0] hist_q;
  logic              agree;

  assign agree = bypass_i | (&{hist_q, s2_q}) | ~(|{hist_q, s2_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      hist_q <= '0;
      pin_o  <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (strobe_i) begin
        hist_q <= {hist_q[HIST_W-2:0], s2_q};
        if (agree) pin_o <= s2_q;
      end
    end
  end

  // R10
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(pin_o));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int              WIDTH    = 16,
  parameter int              QUAL_W   = 8,
  parameter logic [WIDTH-1:0] PIN_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  latch_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  mux_o,
  output logic [QUAL_W-1:0] qual_o
);
  logic [WIDTH-1:0] wmask;
  assign wmask = wdata_i & PIN_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
      mux_o   <= '0;
      qual_o  <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(addr_i))
        REG_DATA: latch_o <= wmask;
        REG_SET:  latch_o <= latch_o | wmask;
        REG_CLR:  latch_o <= latch_o & ~wmask;
        REG_TGL:  latch_o <= latch_o ^ wmask;
        REG_DIR:  dir_o   <= wmask;
        REG_MUX:  mux_o   <= wmask;
        REG_QUAL: qual_o  <= wdata_i[QUAL_W-1:0];
        default:  ;
      endcase
    end
  end

  // R4
  set_forces_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_SET) |=>
      ((latch_o & $past(wdata_i & PIN_MASK)) == $past(wdata_i & PIN_MASK)));
  // R5
  clr_forces_zeros_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_CLR) |=> ((latch_o & $past(wdata_i)) == '0));
  // R6
  tgl_inverts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_TGL) |=>
      (latch_o == ($past(latch_o) ^ $past(wdata_i & PIN_MASK))));
  // R11
  unimpl_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_o | dir_o | mux_o) & ~PIN_MASK) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 16,
  parameter int NUM_PINS = 16,
  parameter int QUAL_W   = 8,
  parameter int SAMPLES  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pad_in_i,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_out_o
);
  localparam logic [WIDTH-1:0] PIN_MASK = {WIDTH{1'b1}} >> (WIDTH - NUM_PINS);

  logic [WIDTH-1:0]  latch, dir, mux, pins_q;
  logic [QUAL_W-1:0] qual;
  logic              strobe, bypass;

  gpio_regs #(.WIDTH(WIDTH), .QUAL_W(QUAL_W), .PIN_MASK(PIN_MASK)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .latch_o(latch), .dir_o(dir), .mux_o(mux), .qual_o(qual)
  );

  gpio_qual_tick #(.QUAL_W(QUAL_W)) u_tick (
    .clk_i, .rst_ni, .qual_i(qual), .strobe_o(strobe), .bypass_o(bypass)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < NUM_PINS) begin : g_impl
      gpio_pin_qual #(.SAMPLES(SAMPLES)) u_qual (
        .clk_i, .rst_ni, .pin_i(pad_in_i[i]), .strobe_i(strobe),
        .bypass_i(bypass), .pin_o(pins_q[i])
      );
    end else begin : g_none
      assign pins_q[i] = 1'b0 & pad_in_i[i];
    end
  end

  assign pad_oe_o  = dir & ~mux;
  assign pad_out_o = latch;

  always_comb begin
    case (reg_addr_e'(addr_i))
      REG_DATA: rdata_o = pins_q;
      REG_DIR:  rdata_o = dir;
      REG_MUX:  rdata_o = mux;
      REG_QUAL: rdata_o = WIDTH'(qual);
      default:  rdata_o = '0;
    endcase
  end

  // R8
  wo_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_SET || addr_i == REG_CLR || addr_i == REG_TGL) |-> (rdata_o == '0));
  // R3
  handed_pin_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & u_regs.mux_o) == '0);
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr  = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic        loop_en = 1'b0;
  logic [15:0] ext = 16'h0;

  logic [1:0][15:0] rdata, oe, pout, pin, env;
  int vectors = 0;
  int miscompares = 0;

  gpio_port u_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata[0]), .pad_in_i(pin[0]), .pad_oe_o(oe[0]), .pad_out_o(pout[0])
  );
  gpio_port #(.NUM_PINS(15)) u_gpio_port_n15 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata[1]), .pad_in_i(pin[1]), .pad_oe_o(oe[1]), .pad_out_o(pout[1])
  );

  for (genvar k = 0; k < 2; k++) begin : g_env
    assign env[k] = loop_en ? {pout[k][7:0], pout[k][15:8]} : ext;
    assign pin[k] = (oe[k] & pout[k]) | (~oe[k] & env[k]);
  end

  // behavioural reference
  logic [1:0][15:0] mask = {16'h7FFF, 16'hFFFF};
  logic [1:0][15:0] m_latch, m_dir, m_mux, m_s1, m_s2, m_pq;
  logic [1:0][7:0]  m_qual;
  int               m_cnt [2];
  logic [4:0]       m_hist [2][16];
  logic             t_strb, t_s;
  int               t_lim;
  logic [15:0]      t_wm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_latch[k] = 0; m_dir[k] = 0; m_mux[k] = 0; m_qual[k] = 0;
        m_s1[k] = 0; m_s2[k] = 0; m_pq[k] = 0; m_cnt[k] = 0;
        for (int b = 0; b < 16; b++) m_hist[k][b] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        t_lim  = 2 * int'(m_qual[k]) - 1;
        t_strb = (m_qual[k] == 0) || (m_cnt[k] >= t_lim);
        for (int b = 0; b < 16; b++) begin
          if (mask[k][b] && t_strb) begin
            t_s = m_s2[k][b];
            if (m_qual[k] == 0 || (t_s && m_hist[k][b] == 5'h1F) || (!t_s && m_hist[k][b] == 5'h00))
              m_pq[k][b] = t_s;
            m_hist[k][b] = {m_hist[k][b][3:0], t_s};
          end
        end
        if (m_qual[k] == 0 || t_strb) m_cnt[k] = 0;
        else m_cnt[k] = m_cnt[k] + 1;
        m_s2[k] = m_s1[k];
        m_s1[k] = pin[k] & mask[k];
        t_wm = wdata & mask[k];
        if (wr_en) begin
          case (addr)
            3'd0: m_latch[k] = t_wm;
            3'd1: m_latch[k] = m_latch[k] | t_wm;
            3'd2: m_latch[k] = m_latch[k] & ~t_wm;
            3'd3: m_latch[k] = m_latch[k] ^ t_wm;
            3'd4: m_dir[k] = t_wm;
            3'd5: m_mux[k] = t_wm;
            3'd6: m_qual[k] = wdata[7:0];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [15:0] model_rd(int k, logic [2:0] a);
    case (a)
      3'd0: return m_pq[k];
      3'd4: return m_dir[k];
      3'd5: return m_mux[k];
      3'd6: return {8'h00, m_qual[k]};
      default: return 16'h0;
    endcase
  endfunction

  // per-cycle comparison against the model (R1..R12)
  always @(negedge clk) begin
    #2;
    for (int k = 0; k < 2; k++) begin
      vectors++;
      if (rdata[k] !== model_rd(k, addr) || oe[k] !== (m_dir[k] & ~m_mux[k]) || pout[k] !== m_latch[k]) begin
        miscompares++;
        $display("FAIL model inst%0d addr%0d: rd/oe/out actual %h/%h/%h expected %h/%h/%h",
                 k, addr, rdata[k], oe[k], pout[k], model_rd(k, addr), m_dir[k] & ~m_mux[k], m_latch[k]);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 3'd0;
  endtask

  task automatic rd2(string tag, logic [2:0] a, logic [15:0] e0, logic [15:0] e1);
    @(negedge clk); addr = a; #1;
    chk({tag, " full"}, rdata[0], e0);
    chk({tag, " n15"},  rdata[1], e1);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd2("R1 data", 3'd0, 16'h0, 16'h0);
    rd2("R1 dir",  3'd4, 16'h0, 16'h0);
    rd2("R1 mux",  3'd5, 16'h0, 16'h0);
    rd2("R1 qual", 3'd6, 16'h0, 16'h0);
    chk("R1 oe", oe[0], 16'h0);

    // R2 / R12 upper byte drives lower byte
    loop_en = 1'b1;
    wr(3'd4, 16'hFF00);
    chk("R2 oe full", oe[0], 16'hFF00);
    chk("R2 oe n15", oe[1], 16'h7F00);
    for (int rep = 0; rep < 2; rep++) begin
      wr(3'd2, 16'hFF00); idle(3);
      rd2("R12 clear", 3'd0, 16'h0000, 16'h0000);
      wr(3'd1, 16'h5500); idle(3);
      rd2("R12 set", 3'd0, 16'h5555, 16'h5555);
      wr(3'd3, 16'hFF00); idle(3);
      rd2("R12 toggle", 3'd0, 16'hAAAA, 16'h2A2A);
    end
    // reversed direction
    wr(3'd4, 16'h00FF);
    wr(3'd2, 16'h00FF); idle(3);
    rd2("R12 rev clear", 3'd0, 16'h0000, 16'h0000);
    wr(3'd1, 16'h00AA); idle(3);
    rd2("R12 rev set", 3'd0, 16'hAAAA, 16'h2AAA);
    wr(3'd3, 16'h0055); idle(3);
    rd2("R12 rev toggle", 3'd0, 16'hFFFF, 16'h7FFF);

    // R3 pin function hands pins away
    wr(3'd4, 16'hFFFF);
    wr(3'd5, 16'h0FF0);
    chk("R3 oe full", oe[0], 16'hF00F);
    chk("R3 oe n15", oe[1], 16'h700F);
    rd2("R3 mux read", 3'd5, 16'h0FF0, 16'h0FF0);
    wr(3'd5, 16'h0000);
    chk("R3 oe restored", oe[0], 16'hFFFF);
    rd2("R11 dir", 3'd4, 16'hFFFF, 16'h7FFF);

    // R7 data read returns pins, not latch
    loop_en = 1'b0; ext = 16'h0000;
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h1234); idle(4);
    chk("R7 out", pout[0], 16'h1234);
    rd2("R7 pins low", 3'd0, 16'h0000, 16'h0000);
    ext = 16'hBEEF; idle(4);
    rd2("R7 pins ext", 3'd0, 16'hBEEF, 16'h3EEF);

    // R8 write-only and unused addresses
    rd2("R8 set", 3'd1, 16'h0, 16'h0);
    rd2("R8 clr", 3'd2, 16'h0, 16'h0);
    rd2("R8 tgl", 3'd3, 16'h0, 16'h0);
    rd2("R8 spare", 3'd7, 16'h0, 16'h0);

    // R4 R5 R6 bit-level updates
    wr(3'd0, 16'h00F0);
    wr(3'd1, 16'h0F00);
    chk("R4 set", pout[0], 16'h0FF0);
    wr(3'd2, 16'h0030);
    chk("R5 clear", pout[0], 16'h0FC0);
    wr(3'd3, 16'hFFFF);
    chk("R6 toggle full", pout[0], 16'hF03F);
    chk("R6 toggle n15", pout[1], 16'h703F);
    wr(3'd1, 16'h8000);
    chk("R11 out15", pout[1], 16'h703F);

    // R9 unqualified latency
    ext = 16'h0000; idle(4);
    @(negedge clk); ext = 16'h00FF;
    rd2("R9 edge1", 3'd0, 16'h0000, 16'h0000);
    rd2("R9 edge2", 3'd0, 16'h0000, 16'h0000);
    rd2("R9 edge3", 3'd0, 16'h00FF, 16'h00FF);

    // R10 qualification
    ext = 16'h0000;
    wr(3'd6, 16'h0002);
    rd2("R10 qual read", 3'd6, 16'h0002, 16'h0002);
    idle(40);
    rd2("R10 settled low", 3'd0, 16'h0000, 16'h0000);
    ext = 16'hFFFF; idle(8); ext = 16'h0000;
    idle(40);
    rd2("R10 pulse rejected", 3'd0, 16'h0000, 16'h0000);
    ext = 16'hFFFF; idle(40);
    rd2("R10 level accepted", 3'd0, 16'hFFFF, 16'h7FFF);
    ext = 16'h0000; idle(5);
    rd2("R10 not yet low", 3'd0, 16'hFFFF, 16'h7FFF);
    idle(30);
    rd2("R10 low accepted", 3'd0, 16'h0000, 16'h0000);

    idle(2);
    finish_run();
  end
endmodule